// File: doc/BRIEF.md
# Sequenced Stream Request Master

This block issues remote read and write transactions as packets of 32-bit words on a valid/ready/last output stream and takes the replies from a matching input stream. A command port takes the operation, a target address and a word count. Write payload words are pushed in advance into an internal FIFO. Read payload words come out on a data port as the reply delivers them. `done_o` pulses once for each request that completes.

Every request carries a sequence number. The remote side may reject a request with a NACK that states which sequence number it expects. The block then adopts that number and sends the identical request again. A reply that does not arrive in time also counts as a failed attempt. After the third failed attempt, or on any reply of an unexpected type, the block gives up on the command and raises a sticky error flag.

Top module: `seq_req_master`

## Requirements
- R1: A read request is two words. The first word holds type code 1 in bits 2:0, the sequence number in bits 15:3 and the word count in bits 22:16, with the other bits zero. The second word is the address, and `tx_last_o` is high on it.
- R2: A write request is a header word followed by the address word and then the payload words. The header holds type code 2 in bits 2:0, the sequence number in bits 15:3, and zeros in bits 31:16. The payload is the count words taken from the write FIFO in push order, and `tx_last_o` is high on the final payload word.
- R3: A reply header carries its type in bits 31:29 and a sequence number in bits 28:16. The types are 3 for a read reply, 4 for a write reply and 5 for a NACK. Each read reply word after the header appears on `rd_data_o` with `rd_valid_o` one cycle after it is accepted. `done_o` pulses one cycle after the reply finishes.
- R4: The sequence number is 0 after reset. It increments by one for each completed request and wraps from 8191 to 0.
- R5: On a NACK, the sequence number is replaced with reply bits 28:16. The same request (address, count and payload) is then sent again carrying that number.
- R6: If no reply header arrives within `tmo_cycles_i`+1 cycles of the request's last word, the attempt counts as failed. The request is resent with its sequence number unchanged.
- R7: When the third attempt of a request fails, `err_o` is set and the command is dropped, including its write payload. No further words are sent for that command, and the block becomes ready for the next command.
- R8: A reply header of any type other than the expected reply type or NACK sets `err_o` and drops the command, with no `done_o` and no read data.
- R9: A command with a count of 0 or above 126 is refused. It sets `err_o`, and nothing is transmitted.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_last_o` hold their values.
- R11: After reset, `cmd_ready_o` is 1 and `tx_valid_o`, `err_o` and `done_o` are 0. Once set, `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 32 | Target address |
| cmd_len_i | input | 7 | Word count, 1 to 126 |
| wr_valid_i | input | 1 | Write payload word offered |
| wr_ready_o | output | 1 | Write FIFO has room |
| wr_data_i | input | 32 | Write payload word |
| rd_valid_o | output | 1 | Read payload word valid |
| rd_data_o | output | 32 | Read payload word |
| tx_valid_o | output | 1 | Request word valid |
| tx_ready_i | input | 1 | Request word accepted |
| tx_last_o | output | 1 | Final word of request |
| tx_data_o | output | 32 | Request word |
| rx_valid_i | input | 1 | Reply word valid |
| rx_ready_o | output | 1 | Reply word accepted |
| rx_last_i | input | 1 | Final word of reply |
| rx_data_i | input | 32 | Reply word |
| tmo_cycles_i | input | 16 | Reply timeout in cycles |
| done_o | output | 1 | Request completed (pulse) |
| err_o | output | 1 | Sticky error |

## Verification
The bench first walks a table of reads and writes, including single-word requests and the 126-word limit. Each request's header, address and payload are compared against values built from the field layout.

Directed cases then cover the following:
- A NACK that moves the sequence number to an arbitrary value. A design that ignored the reply field would resend the stale number.
- A NACK to 8191 followed by a success. This exposes a counter that fails to wrap.
- A silent remote. A design missing the timer would hang.
- Three NACKs in a row. Retrying forever, or leaving the dropped payload in the FIFO, would show up in the next write's data words.
- An unexpected reply type and out-of-range counts, both of which must end in the error flag with the output stream silent.
- A stalled output stream, where words must not change or be lost.

// File: rtl/seq_req_pkg.sv
package seq_req_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DATA,
    ST_TX_HDR,
    ST_TX_ADDR,
    ST_TX_DATA,
    ST_RX_HDR,
    ST_RX_DATA,
    ST_RX_DRAIN
  } srm_state_e;
endpackage

// File: rtl/replay_fifo.sv
// FIFO whose read side can be rewound to the last committed point.
module replay_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  output logic          full_o,
  output logic [AW:0]   avail_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          adv_i,
  input  logic          rewind_i,
  input  logic          commit_i,
  input  logic [AW:0]   commit_n_i
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, head_q, scan_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q[AW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      head_q <= '0;
      scan_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (commit_i) begin
        head_q <= head_q + commit_n_i;
        scan_q <= head_q + commit_n_i;
      end else if (rewind_i) begin
        scan_q <= head_q;
      end else if (adv_i) begin
        scan_q <= scan_q + 1'b1;
      end
    end
  end

  assign avail_o   = wr_q - head_q;
  assign full_o    = (avail_o == (AW+1)'(DEPTH));
  assign rd_data_o = mem[scan_q[AW-1:0]];

  assert_commit_within_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (commit_n_i <= avail_o));
  assert_scan_written_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (scan_q != wr_q));
endmodule

// File: rtl/resp_timer.sv
// Counts cycles spent waiting for a reply header.
module resp_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/seq_req_master.sv
module seq_req_master
  import seq_req_pkg::*;
#(
  parameter int SEQ_W       = 13,
  parameter int LEN_W       = 7,
  parameter int MAX_LEN     = 126,
  parameter int MAX_TRIES   = 3,
  parameter int FIFO_DEPTH  = 128,
  parameter int TMO_W       = 16,
  parameter logic [2:0] T_RD_REQ = 3'd1,
  parameter logic [2:0] T_WR_REQ = 3'd2,
  parameter logic [2:0] T_RD_RSP = 3'd3,
  parameter logic [2:0] T_WR_RSP = 3'd4,
  parameter logic [2:0] T_NACK   = 3'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [WORD_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_last_o,
  output logic [WORD_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic              rx_last_i,
  input  logic [WORD_W-1:0] rx_data_i,
  input  logic [TMO_W-1:0]  tmo_cycles_i,
  output logic              done_o,
  output logic              err_o
);
  localparam int FIFO_AW    = $clog2(FIFO_DEPTH);
  localparam int TRY_W      = $clog2(MAX_TRIES + 1);
  localparam int HDR_SEQ_LO = 3;
  localparam int HDR_LEN_LO = 16;
  localparam int RSP_SEQ_LO = 16;
  localparam int RSP_TYP_LO = 29;

  srm_state_e state_q, drain_to_q, hdr_next;
  logic              write_q, err_q, done_q, rd_valid_q;
  logic [WORD_W-1:0] addr_q, rd_data_q, hdr_word, fifo_word;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [TRY_W-1:0]  tries_q;
  logic [SEQ_W-1:0]  seq_q, rsp_seq;
  logic [2:0]        rsp_type, exp_type;
  logic [FIFO_AW:0]  fifo_avail;
  logic fifo_full, tmo_expired;
  logic in_hdr, ok_hdr, nack, bad_type, tmo_hit, failed_try, give_up, retry;
  logic success, abandon, len_bad, hdr_to_data;

  replay_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i      (wr_valid_i && !fifo_full),
    .push_data_i (wr_data_i),
    .full_o      (fifo_full),
    .avail_o     (fifo_avail),
    .rd_data_o   (fifo_word),
    .adv_i       (state_q == ST_TX_DATA && tx_ready_i),
    .rewind_i    (retry),
    .commit_i    (write_q && (success || abandon)),
    .commit_n_i  ((FIFO_AW+1)'(len_q))
  );

  resp_timer #(.W(TMO_W)) u_timer (
    .clk_i, .rst_ni,
    .run_i     (state_q == ST_RX_HDR),
    .limit_i   (tmo_cycles_i),
    .expired_o (tmo_expired)
  );

  // reply classification
  assign rsp_type    = rx_data_i[RSP_TYP_LO +: 3];
  assign rsp_seq     = rx_data_i[RSP_SEQ_LO +: SEQ_W];
  assign exp_type    = write_q ? T_WR_RSP : T_RD_RSP;
  assign in_hdr      = (state_q == ST_RX_HDR) && rx_valid_i;
  assign ok_hdr      = in_hdr && (rsp_type == exp_type);
  assign nack        = in_hdr && (rsp_type == T_NACK);
  assign bad_type    = in_hdr && !ok_hdr && !nack;
  assign tmo_hit     = (state_q == ST_RX_HDR) && !rx_valid_i && tmo_expired;
  assign failed_try  = nack || tmo_hit;
  assign give_up     = failed_try && (tries_q == TRY_W'(MAX_TRIES - 1));
  assign retry       = failed_try && !give_up;
  assign hdr_to_data = ok_hdr && !write_q && !rx_last_i;
  assign success     = (ok_hdr && (write_q || rx_last_i))
                     || (state_q == ST_RX_DATA && rx_valid_i && rx_last_i);
  assign abandon     = give_up || bad_type;
  assign len_bad     = (state_q == ST_IDLE) && cmd_valid_i
                     && (cmd_len_i == '0 || cmd_len_i > LEN_W'(MAX_LEN));

  always_comb begin
    if (hdr_to_data)            hdr_next = ST_RX_DATA;
    else if (success || abandon) hdr_next = ST_IDLE;
    else                        hdr_next = ST_TX_HDR;
  end

  always_comb begin
    hdr_word = '0;
    hdr_word[2:0] = write_q ? T_WR_REQ : T_RD_REQ;
    hdr_word[HDR_SEQ_LO +: SEQ_W] = seq_q;
    if (!write_q) hdr_word[HDR_LEN_LO +: LEN_W] = len_q;
  end

  always_comb begin
    case (state_q)
      ST_TX_HDR:  tx_data_o = hdr_word;
      ST_TX_ADDR: tx_data_o = addr_q;
      ST_TX_DATA: tx_data_o = fifo_word;
      default:    tx_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      drain_to_q <= ST_IDLE;
      write_q    <= 1'b0;
      addr_q     <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      tries_q    <= '0;
      seq_q      <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q     <= success;
      rd_valid_q <= (state_q == ST_RX_DATA) && rx_valid_i;
      if (state_q == ST_RX_DATA && rx_valid_i) rd_data_q <= rx_data_i;
      if (success)   seq_q <= seq_q + 1'b1;
      else if (nack) seq_q <= rsp_seq;
      if (abandon || len_bad) err_q <= 1'b1;
      if (retry) tries_q <= tries_q + 1'b1;

      case (state_q)
        ST_IDLE: if (cmd_valid_i && !len_bad) begin
          write_q <= cmd_write_i;
          addr_q  <= cmd_addr_i;
          len_q   <= cmd_len_i;
          tries_q <= '0;
          state_q <= cmd_write_i ? ST_WAIT_DATA : ST_TX_HDR;
        end
        ST_WAIT_DATA:
          if (fifo_avail >= (FIFO_AW+1)'(len_q)) state_q <= ST_TX_HDR;
        ST_TX_HDR: if (tx_ready_i) state_q <= ST_TX_ADDR;
        ST_TX_ADDR: if (tx_ready_i) begin
          idx_q   <= '0;
          state_q <= write_q ? ST_TX_DATA : ST_RX_HDR;
        end
        ST_TX_DATA: if (tx_ready_i) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == len_q - 1'b1) state_q <= ST_RX_HDR;
        end
        ST_RX_HDR: begin
          if (rx_valid_i) begin
            if (!rx_last_i && !hdr_to_data) begin
              state_q    <= ST_RX_DRAIN;
              drain_to_q <= hdr_next;
            end else begin
              state_q <= hdr_next;
            end
          end else if (tmo_hit) begin
            state_q <= give_up ? ST_IDLE : ST_TX_HDR;
          end
        end
        ST_RX_DATA:  if (rx_valid_i && rx_last_i) state_q <= ST_IDLE;
        ST_RX_DRAIN: if (rx_valid_i && rx_last_i) state_q <= drain_to_q;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign wr_ready_o  = !fifo_full;
  assign tx_valid_o  = (state_q == ST_TX_HDR) || (state_q == ST_TX_ADDR)
                    || (state_q == ST_TX_DATA);
  assign tx_last_o   = (state_q == ST_TX_ADDR && !write_q)
                    || (state_q == ST_TX_DATA && idx_q == len_q - 1'b1);
  assign rx_ready_o  = (state_q == ST_RX_HDR) || (state_q == ST_RX_DATA)
                    || (state_q == ST_RX_DRAIN);
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_try_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q < TRY_W'(MAX_TRIES));
  assert_len_refused_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_bad |=> !tx_valid_o && err_o);
  assert_tmo_leaves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_expired |=> state_q != ST_RX_HDR);
endmodule

// File: tb/tb_seq_req_master.sv
`timescale 1ns/1ps
module tb_seq_req_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, wr_valid = 0, tx_ready = 1;
  logic rx_valid = 0, rx_last = 0;
  logic [31:0] cmd_addr = 0, wr_data = 0, rx_data = 0;
  logic [6:0]  cmd_len = 0;
  logic [15:0] tmo = 16'd200;
  logic cmd_ready, wr_ready, rd_valid, tx_valid, tx_last, rx_ready, done, err;
  logic [31:0] rd_data, tx_data;

  seq_req_master dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_last_o(tx_last), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_last_i(rx_last), .rx_data_i(rx_data),
    .tmo_cycles_i(tmo), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] pkt [256];
  logic [31:0] rxw [256];
  logic [31:0] pushw [256];
  logic [31:0] rd_buf [1024];
  int pkt_n = 0, rd_cnt = 0, done_cnt = 0;
  logic [12:0] seq_m = 0;

  always @(negedge clk) begin
    if (rd_valid) begin rd_buf[rd_cnt % 1024] = rd_data; rd_cnt++; end
    if (done) done_cnt++;
  end

  localparam logic [39:0] VECS [0:5] = '{
    {1'b0, 32'h0000_1000, 7'd1},
    {1'b1, 32'h0000_2000, 7'd1},
    {1'b0, 32'h0000_ABC0, 7'd5},
    {1'b1, 32'h1234_5678, 7'd4},
    {1'b1, 32'h0000_0040, 7'd126},
    {1'b0, 32'hFFFF_FF80, 7'd126}
  };

  function automatic logic [31:0] rd_hdr(input logic [12:0] s, input logic [6:0] l);
    return {9'b0, l, s, 3'd1};
  endfunction
  function automatic logic [31:0] wr_hdr(input logic [12:0] s);
    return {16'b0, s, 3'd2};
  endfunction
  function automatic logic [31:0] rsp(input logic [2:0] t, input logic [12:0] s);
    return {t, s, 16'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    seq_m = 0;
    @(negedge clk);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = pushw[i];
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic do_cmd(input logic w, input logic [31:0] a, input logic [6:0] l);
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_len = l;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic collect(input bit bp);
    int guard = 0;
    pkt_n = 0;
    while (guard < 3000) begin
      tx_ready = bp ? ((guard % 3) != 0) : 1'b1;
      if (tx_valid && tx_ready) begin
        pkt[pkt_n] = tx_data; pkt_n++;
        if (tx_last) break;
      end
      @(negedge clk); guard++;
    end
    tx_ready = 1;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = rxw[i]; rx_last = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0;
  endtask

  task automatic check_req(input string tag, input logic w, input logic [31:0] a,
                           input int l, input logic [12:0] s);
    int bad = 0;
    chk({tag, " header"}, pkt[0], w ? wr_hdr(s) : rd_hdr(s, 7'(l)));
    chk({tag, " address"}, pkt[1], a);
    chk({tag, " word count"}, pkt_n, w ? l + 2 : 2);
    if (w) begin
      for (int i = 0; i < l; i++) if (pkt[2+i] !== pushw[i]) bad++;
      chk({tag, " payload"}, bad, 0);
    end
  endtask

  // good reply, checks done and read data
  task automatic reply_ok(input string tag, input logic w, input logic [31:0] a, input int l);
    int d0 = done_cnt, r0 = rd_cnt, bad = 0;
    if (w) begin
      rxw[0] = rsp(3'd4, seq_m); send(1);
    end else begin
      rxw[0] = rsp(3'd3, seq_m);
      for (int i = 0; i < l; i++) rxw[1+i] = a ^ 32'h5A5A_0000 ^ 32'(i);
      send(l + 1);
    end
    @(negedge clk);
    chk({tag, " R3 done"}, done_cnt, d0 + 1);
    if (!w) begin
      chk({tag, " R3 read count"}, rd_cnt - r0, l);
      for (int i = 0; i < l; i++)
        if (rd_buf[(r0 + i) % 1024] !== (a ^ 32'h5A5A_0000 ^ 32'(i))) bad++;
      chk({tag, " R3 read data"}, bad, 0);
    end
    seq_m = seq_m + 1'b1;
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      if (tx_valid) seen++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int seen, wt, r0, d0;
    logic w;
    logic [31:0] a;
    int l;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset cmd_ready", cmd_ready, 1);
    chk("R11 reset tx_valid", tx_valid, 0);
    chk("R11 reset err", err, 0);
    chk("R11 reset done", done, 0);

    // table walk: R1 / R2 / R3 / R4
    for (int v = 0; v < 6; v++) begin
      w = VECS[v][39]; a = VECS[v][38:7]; l = int'(VECS[v][6:0]);
      if (w) begin
        for (int i = 0; i < l; i++) pushw[i] = a + 32'(i) * 32'h0101_0101;
        push(l);
      end
      do_cmd(w, a, 7'(l));
      collect(0);
      check_req(w ? "R2 R4 vec" : "R1 R4 vec", w, a, l, seq_m);
      reply_ok("vec", w, a, l);
    end

    // R5 NACK resync and resend
    pushw[0] = 32'hCAFE_0001; pushw[1] = 32'hCAFE_0002;
    push(2);
    do_cmd(1, 32'h300, 7'd2);
    collect(0);
    check_req("R5 first", 1, 32'h300, 2, seq_m);
    rxw[0] = rsp(3'd5, 13'h155); send(1);
    collect(0);
    seq_m = 13'h155;
    check_req("R5 resend", 1, 32'h300, 2, seq_m);
    reply_ok("R5", 1, 32'h300, 2);

    // R4 wrap via NACK to 8191
    do_cmd(0, 32'h440, 7'd1);
    collect(0);
    rxw[0] = rsp(3'd5, 13'h1FFF); send(1);
    collect(0);
    seq_m = 13'h1FFF;
    check_req("R4 max seq", 0, 32'h440, 1, seq_m);
    reply_ok("R4", 0, 32'h440, 1);
    chk("R4 wrap model", seq_m, 0);
    do_cmd(0, 32'h500, 7'd2);
    collect(0);
    check_req("R4 wrapped", 0, 32'h500, 2, seq_m);
    reply_ok("R4b", 0, 32'h500, 2);

    // R6 timeout resend
    tmo = 16'd30;
    do_cmd(0, 32'h600, 7'd3);
    collect(0);
    check_req("R6 first", 0, 32'h600, 3, seq_m);
    @(negedge clk);
    wt = 0;
    while (!tx_valid && wt < 1000) begin @(negedge clk); wt++; end
    chk("R6 resend delay window", (wt >= 30 && wt <= 40), 1);
    collect(0);
    check_req("R6 resend", 0, 32'h600, 3, seq_m);
    reply_ok("R6", 0, 32'h600, 3);
    tmo = 16'd200;

    // R10 backpressure
    pushw[0] = 32'h1111_AAAA; pushw[1] = 32'h2222_BBBB; pushw[2] = 32'h3333_CCCC;
    push(3);
    do_cmd(1, 32'h700, 7'd3);
    collect(1);
    check_req("R10 stalled", 1, 32'h700, 3, seq_m);
    reply_ok("R10", 1, 32'h700, 3);
    chk("R11 err clear after good traffic", err, 0);

    // R7 give up after three NACKs
    do_reset();
    pushw[0] = 32'hDEAD_0001; pushw[1] = 32'hDEAD_0002;
    push(2);
    do_cmd(1, 32'h800, 7'd2);
    collect(0);
    rxw[0] = rsp(3'd5, 13'd7); send(1);
    collect(0);
    rxw[0] = rsp(3'd5, 13'd8); send(1);
    collect(0);
    chk("R7 third attempt seq", pkt[0], wr_hdr(13'd8));
    rxw[0] = rsp(3'd5, 13'd9); send(1);
    quiet(40, seen);
    chk("R7 no fourth attempt", seen, 0);
    chk("R7 err set", err, 1);
    chk("R7 ready again", cmd_ready, 1);
    seq_m = 13'd9;
    pushw[0] = 32'hBEEF_0001; pushw[1] = 32'hBEEF_0002;
    push(2);
    do_cmd(1, 32'h900, 7'd2);
    collect(0);
    check_req("R7 payload dropped", 1, 32'h900, 2, seq_m);
    reply_ok("R7", 1, 32'h900, 2);
    chk("R11 err sticky", err, 1);

    // R8 unexpected reply type
    do_reset();
    do_cmd(0, 32'hA00, 7'd2);
    collect(0);
    r0 = rd_cnt; d0 = done_cnt;
    rxw[0] = rsp(3'd4, seq_m); send(1);
    quiet(10, seen);
    chk("R8 err set", err, 1);
    chk("R8 no done", done_cnt, d0);
    chk("R8 no read data", rd_cnt, r0);
    chk("R8 ready again", cmd_ready, 1);
    chk("R8 nothing resent", seen, 0);

    // R9 length refusals
    do_reset();
    do_cmd(0, 32'hB00, 7'd0);
    quiet(20, seen);
    chk("R9 len0 silent", seen, 0);
    chk("R9 len0 err", err, 1);
    do_reset();
    do_cmd(1, 32'hB00, 7'd127);
    quiet(20, seen);
    chk("R9 len127 silent", seen, 0);
    chk("R9 len127 err", err, 1);

    finish_run();
  end
endmodule